// File: doc/BRIEF.md
# Signed 17x17 Multiply-Accumulate Unit

This block is the multiply-accumulate stage of a fixed-point DSP datapath. Each 16-bit operand is first widened to 17 bits. A per-operand flag chooses sign extension or zero extension, so one signed 17x17 multiplier serves signed, unsigned and mixed products. The 34-bit product is sign-extended to the accumulator width. In fractional mode it is doubled. It is then passed through on its own, added to a 40-bit accumulator value, or subtracted from it. All of this happens in a single cycle, followed by one output register.

The second multiplier operand can come from a 16-bit holding register instead of the B input. That register is loaded through its own port. The caller supplies the accumulator value and receives the 40-bit result together with an overflow flag. The accumulator register file itself lives outside the block.

Top module: `mac17_unit`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, out_valid, result and ovf are all 0.
- R2: Each operand is widened to 17 bits separately. When its signed flag is 1 the operand is sign-extended; when the flag is 0 it is zero-extended. The two widened operands are multiplied as two's complement numbers.
- R3: op_sel selects the operation. 2'b00 gives the product alone. 2'b01 gives acc_in plus the product. 2'b10 gives acc_in minus the product. 2'b11 behaves exactly like 2'b00. In every case the 40-bit sum wraps modulo 2^40.
- R4: When frac_mode is 1, the product is shifted left by one bit, after sign extension to 40 bits and before the add or subtract.
- R5: ovf is 1 when the two's complement 40-bit add (2'b01) or subtract (2'b10) overflows. ovf is always 0 for the product-only codes.
- R6: The holding register takes t_din at every rising clock edge where t_load is 1. When b_from_t is 1, it replaces b_in as the B operand, with b_signed still choosing its extension. A load in the same cycle as a use supplies the value held before that edge. The register resets to 0.
- R7: out_valid equals in_valid delayed by one clock. The result and ovf shown with out_valid belong to the inputs that were present with in_valid.
- R8: When in_valid is 0, result and ovf keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op_sel | input | 2 | 00/11 product, 01 add, 10 subtract |
| frac_mode | input | 1 | 1 doubles the product (fractional) |
| a_in | input | 16 | Operand A |
| a_signed | input | 1 | 1 sign-extends A, 0 zero-extends |
| b_in | input | 16 | Operand B |
| b_signed | input | 1 | 1 sign-extends B (or the held value), 0 zero-extends |
| b_from_t | input | 1 | 1 takes B from the holding register |
| t_load | input | 1 | Load the holding register |
| t_din | input | 16 | Holding register load value |
| acc_in | input | 40 | Accumulator operand |
| out_valid | output | 1 | Result valid |
| result | output | 40 | Registered result |
| ovf | output | 1 | 40-bit add/subtract overflow |

## Verification
The directed cases go after the extreme operands: 0x8000 squared as signed, and 0xFFFF squared as unsigned and as signed. Mixing up the extension flags turns the unsigned square into 1, or the signed one into a huge positive value. Accumulators sitting at the positive and negative 40-bit limits are pushed past them in each direction. A design that reverses the overflow test, or that flags the product-only codes, shows the wrong ovf. The bench loads the holding register in the same cycle that it uses the register, which separates a design that forwards the new value from one that uses the held value. Random operations with random modes then compare every result against an exact wide-integer model.

// File: rtl/mac17_pkg.sv
package mac17_pkg;
  typedef enum logic [1:0] {
    OP_MPY  = 2'b00,
    OP_MAC  = 2'b01,
    OP_MSU  = 2'b10,
    OP_MPY2 = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac17_ext.sv
module mac17_ext #(
  parameter int IW = 16
) (
  input  logic [IW-1:0] val,
  input  logic          is_signed,
  output logic [IW:0]   wide
);
  function automatic logic [IW:0] widen(input logic [IW-1:0] v, input logic s);
    return {s & v[IW-1], v};
  endfunction

  assign wide = widen(val, is_signed);
endmodule

// File: rtl/mac17_mul.sv
module mac17_mul #(
  parameter int IW = 16,
  parameter int AW = 40
) (
  input  logic [IW:0]   xa,
  input  logic [IW:0]   xb,
  input  logic          frac,
  output logic [AW-1:0] prod
);
  localparam int XW = IW + 1;
  localparam int PW = 2 * XW;

  logic signed [PW-1:0] raw;
  logic        [AW-1:0] sext;

  assign raw  = $signed(xa) * $signed(xb);
  assign sext = {{(AW-PW){raw[PW-1]}}, raw};
  assign prod = frac ? (sext << 1) : sext;
endmodule

// File: rtl/mac17_addsub.sv
module mac17_addsub #(
  parameter int AW = 40
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] prod,
  input  logic [1:0]    op,
  output logic [AW-1:0] sum,
  output logic          ovf
);
  import mac17_pkg::*;

  function automatic logic add_ovf(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  function automatic logic sub_ovf(input logic sa, input logic sb, input logic ss);
    return (sa != sb) && (ss != sa);
  endfunction

  always_comb begin
    unique case (op)
      OP_MAC: begin
        sum = acc + prod;
        ovf = add_ovf(acc[AW-1], prod[AW-1], sum[AW-1]);
      end
      OP_MSU: begin
        sum = acc - prod;
        ovf = sub_ovf(acc[AW-1], prod[AW-1], sum[AW-1]);
      end
      default: begin
        sum = prod;
        ovf = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mac17_unit.sv
module mac17_unit #(
  parameter int IW = 16,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    op_sel,
  input  logic          frac_mode,
  input  logic [IW-1:0] a_in,
  input  logic          a_signed,
  input  logic [IW-1:0] b_in,
  input  logic          b_signed,
  input  logic          b_from_t,
  input  logic          t_load,
  input  logic [IW-1:0] t_din,
  input  logic [AW-1:0] acc_in,
  output logic          out_valid,
  output logic [AW-1:0] result,
  output logic          ovf
);
  localparam int XW = IW + 1;

  logic [IW-1:0] t_q;
  logic [IW-1:0] b_pick;
  logic [XW-1:0] a_wide, b_wide;
  logic [AW-1:0] prod_w, sum_w;
  logic          ovf_w;

  always_ff @(posedge clk) begin
    if (!rst_n)      t_q <= '0;
    else if (t_load) t_q <= t_din;
  end

  assign b_pick = b_from_t ? t_q : b_in;

  mac17_ext #(.IW(IW)) u_ext_a (.val(a_in),   .is_signed(a_signed), .wide(a_wide));
  mac17_ext #(.IW(IW)) u_ext_b (.val(b_pick), .is_signed(b_signed), .wide(b_wide));

  mac17_mul #(.IW(IW), .AW(AW)) u_mul (
    .xa(a_wide), .xb(b_wide), .frac(frac_mode), .prod(prod_w)
  );

  mac17_addsub #(.AW(AW)) u_addsub (
    .acc(acc_in), .prod(prod_w), .op(op_sel), .sum(sum_w), .ovf(ovf_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sum_w;
        ovf    <= ovf_w;
      end
    end
  end
endmodule

// File: rtl/mac17_unit_chk.sv
module mac17_unit_chk #(
  parameter int IW = 16,
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    op_sel,
  input logic          frac_mode,
  input logic          t_load,
  input logic [IW-1:0] t_din,
  input logic [IW-1:0] t_q,
  input logic          out_valid,
  input logic [AW-1:0] result,
  input logic          ovf
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(ovf)));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == 2'b00 || op_sel == 2'b11)) |=> !ovf);
  assert_frac_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && frac_mode && (op_sel == 2'b00 || op_sel == 2'b11)) |=> !result[0]);
  assert_t_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    t_load |=> (t_q == $past(t_din)));
  assert_t_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !t_load |=> $stable(t_q));
endmodule

bind mac17_unit mac17_unit_chk #(.IW(IW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .frac_mode(frac_mode), .t_load(t_load), .t_din(t_din), .t_q(t_q),
  .out_valid(out_valid), .result(result), .ovf(ovf)
);

// File: tb/sim_mac17_unit.sv
module sim_mac17_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic        frac_mode = 1'b0;
  logic [15:0] a_in = '0, b_in = '0, t_din = '0;
  logic        a_signed = 1'b0, b_signed = 1'b0, b_from_t = 1'b0, t_load = 1'b0;
  logic [39:0] acc_in = '0;
  logic        out_valid, ovf;
  logic [39:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] t_model = '0;
  logic [39:0] last_r = '0;
  logic        last_o = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac17_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .frac_mode(frac_mode), .a_in(a_in), .a_signed(a_signed), .b_in(b_in),
    .b_signed(b_signed), .b_from_t(b_from_t), .t_load(t_load), .t_din(t_din),
    .acc_in(acc_in), .out_valid(out_valid), .result(result), .ovf(ovf)
  );

  function automatic longint widen(input logic [15:0] v, input logic s);
    return s ? longint'($signed(v)) : longint'({48'd0, v});
  endfunction

  function automatic void model(input logic [1:0] op, input logic fr,
      input logic [15:0] a, input logic as_, input logic [15:0] b, input logic bs,
      input logic [39:0] acc, output logic [39:0] r, output logic o);
    longint p, s, accv, maxv, minv;
    maxv = (longint'(1) << 39) - 1;
    minv = -(longint'(1) << 39);
    p = widen(a, as_) * widen(b, bs);
    if (fr) p = p * 2;
    accv = longint'($signed(acc));
    if (op == 2'b01)      s = accv + p;
    else if (op == 2'b10) s = accv - p;
    else                  s = p;
    r = s[39:0];
    o = (op == 2'b01 || op == 2'b10) && (s > maxv || s < minv);
  endfunction

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] op, input logic fr,
      input logic [15:0] a, input logic as_, input logic [15:0] b, input logic bs,
      input logic use_t, input logic tl, input logic [15:0] td, input logic [39:0] acc);
    logic [39:0] er;
    logic        eo;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; frac_mode = fr; a_in = a; a_signed = as_;
    b_in = b; b_signed = bs; b_from_t = use_t; t_load = tl; t_din = td; acc_in = acc;
    model(op, fr, a, as_, use_t ? t_model : b, bs, acc, er, eo);
    if (tl) t_model = td;
    @(negedge clk);
    check({req, " out_valid (R7)"}, {39'd0, out_valid}, 40'd1);
    check({req, " result"}, result, er);
    check({req, " ovf (R5)"}, {39'd0, ovf}, {39'd0, eo});
    last_r = er; last_o = eo;
    in_valid = 1'b0; t_load = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {39'd0, out_valid}, 40'd0);
    check("R1 result in reset", result, 40'd0);
    check("R1 ovf in reset", {39'd0, ovf}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {39'd0, out_valid}, 40'd0);
    check("R1 result after reset", result, 40'd0);

    run("R2 signed min squared", 2'b00, 0, 16'h8000, 1, 16'h8000, 1, 0, 0, 0, 40'd0);
    run("R2 unsigned max squared", 2'b00, 0, 16'hFFFF, 0, 16'hFFFF, 0, 0, 0, 0, 40'd0);
    run("R2 signed minus one squared", 2'b00, 0, 16'hFFFF, 1, 16'hFFFF, 1, 0, 0, 0, 40'd0);
    run("R2 mixed signed a", 2'b00, 0, 16'hFFFF, 1, 16'hFFFF, 0, 0, 0, 0, 40'd0);
    run("R2 mixed signed b", 2'b00, 0, 16'h8000, 0, 16'h8000, 1, 0, 0, 0, 40'd0);
    run("R3 add", 2'b01, 0, 16'd300, 1, 16'd7, 1, 0, 0, 0, 40'd1000);
    run("R3 subtract", 2'b10, 0, 16'd300, 1, 16'd7, 1, 0, 0, 0, 40'd1000);
    run("R3 code 11 product only", 2'b11, 0, 16'h1234, 1, 16'hF00D, 1, 0, 0, 0, 40'h12_3456_789A);
    run("R4 fractional min squared", 2'b00, 1, 16'h8000, 1, 16'h8000, 1, 0, 0, 0, 40'd0);
    run("R4 fractional add", 2'b01, 1, 16'h4000, 1, 16'hC000, 1, 0, 0, 0, 40'd5);
    run("R5 add overflow", 2'b01, 0, 16'd1, 1, 16'd1, 1, 0, 0, 0, 40'h7F_FFFF_FFFF);
    run("R5 subtract overflow", 2'b10, 0, 16'd1, 1, 16'd1, 1, 0, 0, 0, 40'h80_0000_0000);
    run("R5 add negative overflow", 2'b01, 0, 16'hFFFF, 1, 16'd1, 1, 0, 0, 0, 40'h80_0000_0000);
    run("R5 subtract at limit no overflow", 2'b10, 0, 16'hFFFF, 1, 16'd1, 1, 0, 0, 0, 40'h7F_FFFF_FFFE);
    run("R6 load holding reg", 2'b00, 0, 16'd2, 1, 16'd3, 1, 0, 1, 16'hFFFB, 40'd0);
    run("R6 use holding reg", 2'b00, 0, 16'd2, 1, 16'd3, 1, 1, 0, 0, 40'd0);
    run("R6 load and use same cycle", 2'b00, 0, 16'd2, 1, 16'd3, 1, 1, 1, 16'd9, 40'd0);
    run("R6 use new value", 2'b00, 0, 16'd2, 1, 16'd3, 0, 1, 0, 0, 40'd0);

    // R8: idle cycles with changed inputs must not disturb the outputs
    @(negedge clk);
    op_sel = 2'b01; a_in = 16'h7777; b_in = 16'h1111; acc_in = 40'h7F_FFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    check("R8 result held while idle", result, last_r);
    check("R8 ovf held while idle", {39'd0, ovf}, {39'd0, last_o});
    check("R7 out_valid low while idle", {39'd0, out_valid}, 40'd0);

    void'($urandom(32'd2024));
    for (int i = 0; i < 300; i++) begin
      logic [39:0] acc_r;
      acc_r = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      if (i % 7 == 0) acc_r = (i % 2) ? 40'h7F_FFFF_F000 : 40'h80_0000_0F00;
      run("R3 random", 2'($urandom), 1'($urandom), 16'($urandom), 1'($urandom),
          16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), acc_r);
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule